// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide unpacked form and produces the 32-bit IEEE single-precision word for it. The unpacked value arrives as a class code, a sign, a signed unbiased exponent and a 64-bit mantissa whose top bit is the explicit leading one. Three extra bits (guard, round, sticky) sit below the mantissa's last bit. The packer rounds under one of four selectable modes and handles zero, infinity, NaN, subnormal results and exponent overflow. It keeps four sticky status flags.

One operation is accepted per clock while `in_valid` is high. The packed word and `out_valid` appear one clock later. The status flags gather the events of every operation until `flag_clr` is pulsed. An arithmetic pipeline uses this block as its final write-back stage when a result must be stored in single precision.

Top module: `sp_result_packer`

## Requirements
- R1: After reset `out_valid` and all four status flags are 0. Each operation accepted with `in_valid`=1 produces its word on `out_word`, with `out_valid`=1, in the next cycle. `out_valid` is 0 in the cycle after an idle one.
- R2: Class code 00 (zero) produces the input sign in bit 31 and zeros in bits 30:0. It raises no flag.
- R3: Class code 10 (infinity) produces the sign, exponent field (bits 30:23) 255 and fraction (bits 22:0) 0. It raises no flag.
- R4: Class code 11 (NaN) produces the sign and exponent field 255. The fraction is mantissa bits 62:40 with fraction bit 22 forced to 1. It raises no flag.
- R5: For class code 01 (number) with biased exponent (unbiased + 127) of 1 or more, the kept significand is mantissa bits 63:40 and all lower bits are discarded. Rounding mode 00 rounds to nearest with ties to an even last bit. Mode 01 truncates toward zero. Mode 10 rounds toward minus infinity and mode 11 toward plus infinity.
- R6: The inexact flag is set whenever any discarded bit of a number (including guard, round and sticky) is 1.
- R7: When rounding a normal number carries out of the 24-bit significand, the exponent field is one higher and the fraction is 0.
- R8: A number with biased exponent 0 or less sets the underflow flag. Its significand is shifted right by 41 minus the biased exponent, it is rounded, and it is packed with exponent field 0.
- R9: A subnormal result that rounds up into the implicit-one position packs as exponent field 1 and fraction 0.
- R10: A number whose biased exponent after rounding is 255 or more sets the overflow, inexact and operand-error flags together.
- R11: On overflow the result is infinity for mode 00, for mode 11 when positive and for mode 10 when negative. Otherwise it is the sign with exponent field 254 and an all-ones fraction. Mode 01 never gives infinity.
- R12: A status flag, once set, stays set until `flag_clr` is high in a cycle. A clear in the same cycle as an operation leaves exactly that operation's flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 64 | Mantissa, explicit one at bit 63 |
| in_grd | input | 1 | Guard bit below the mantissa |
| in_rnd | input | 1 | Round bit below the guard bit |
| in_stk | input | 1 | Sticky OR of all lower bits |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| flag_clr | input | 1 | Clears the status flags |
| out_valid | output | 1 | `out_word` holds a new result |
| out_word | output | 32 | Packed single-precision word |
| st_inexact | output | 1 | Sticky inexact flag |
| st_underflow | output | 1 | Sticky underflow flag |
| st_overflow | output | 1 | Sticky overflow flag |
| st_operr | output | 1 | Sticky operand-error flag |

## Verification
Each packed word depends only on the operation accepted the cycle before. A wrong shift amount, rounding decision or exponent adjustment therefore shows as a wrong `out_word` in the very next cycle and does not linger. The flags are the only state that carries over between operations. A flag lost or set wrongly stays visible on the status outputs until the next clear, so a model that tracks them every cycle catches the error on the first cycle it exists. Random operands centred on the subnormal and overflow edges exercise the tie, carry and cap cases alongside directed ones.

// File: rtl/spk_pkg.sv
package spk_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'b00,
      CLS_NUM  = 2'b01,
      CLS_INF  = 2'b10,
      CLS_NAN  = 2'b11
   } spk_class_e;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_NEG    = 2'b10,
      RM_TO_POS    = 2'b11
   } spk_rmode_e;

   typedef struct packed {
      logic operr;
      logic ovfl;
      logic unfl;
      logic inex;
   } spk_flags_t;

endpackage

// File: rtl/spk_align.sv
// Picks the kept significand bits and the rounding information for either
// the normal path (fixed shift) or the subnormal path (growing shift).
module spk_align #(
   parameter int MANT_W  = 64,
   parameter int FRAC_W  = 23,
   parameter int EXPIN_W = 16,
   parameter int BIAS    = 127,
   localparam int BX_W   = EXPIN_W + 2,
   localparam int KEEP_W = FRAC_W + 1
) (
   input  logic signed [EXPIN_W-1:0] exp_in,
   input  logic [MANT_W-1:0]         mant,
   input  logic                      grd,
   input  logic                      rnd,
   input  logic                      stk,
   output logic signed [BX_W-1:0]    biased,
   output logic                      subn,
   output logic [KEEP_W-1:0]         kept,
   output logic                      guard,
   output logic                      rest
);
   localparam int NORM_SH = MANT_W - 1 - FRAC_W;
   localparam int SH_CAP  = MANT_W + 2;
   localparam int SH_W    = $clog2(SH_CAP + 1);
   localparam int EXT_W   = MANT_W + 2;
   localparam int WIDE_W  = EXT_W + SH_CAP;
   localparam int LOW_W   = KEEP_W + 2 + SH_CAP;

   if (NORM_SH < 1) begin : g_bad_width
      $error("spk_align: fraction must be narrower than mantissa minus one");
   end

   logic [BX_W-1:0]   deficit;
   logic [SH_W-1:0]   sh;
   logic [WIDE_W-1:0] wide;
   logic [LOW_W-1:0]  low;

   assign biased  = {{2{exp_in[EXPIN_W-1]}}, exp_in} + BX_W'(BIAS);
   assign subn    = biased[BX_W-1] | (biased == '0);
   assign deficit = BX_W'(NORM_SH + 1) - biased;

   always_comb begin
      if (!subn)
         sh = SH_W'(NORM_SH);
      else if (deficit >= BX_W'(SH_CAP))
         sh = SH_W'(SH_CAP);
      else
         sh = deficit[SH_W-1:0];
   end

   assign wide  = {mant, grd, rnd, {SH_CAP{1'b0}}};
   assign low   = LOW_W'(wide >> sh);
   assign kept  = low[LOW_W-1 -: KEEP_W];
   assign guard = low[SH_CAP+1];
   assign rest  = low[SH_CAP] | (|low[SH_CAP-1:0]) | stk;

endmodule

// File: rtl/spk_round.sv
// Four-mode rounding of the kept significand.
module spk_round
   import spk_pkg::*;
#(
   parameter int KEEP_W = 24
) (
   input  logic [KEEP_W-1:0] kept,
   input  logic              guard,
   input  logic              rest,
   input  logic              sign,
   input  logic [1:0]        rmode,
   output logic [KEEP_W:0]   sum,
   output logic              inexact
);
   logic bump;

   assign inexact = guard | rest;

   always_comb begin
      unique case (spk_rmode_e'(rmode))
         RM_NEAR_EVEN: bump = guard & (rest | kept[0]);
         RM_TO_ZERO:   bump = 1'b0;
         RM_TO_NEG:    bump = sign & inexact;
         RM_TO_POS:    bump = ~sign & inexact;
         default:      bump = 1'b0;
      endcase
   end

   assign sum = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};

endmodule

// File: rtl/spk_assemble.sv
// Builds the packed word and the per-operation flags from class, rounded
// significand and exponent.
module spk_assemble
   import spk_pkg::*;
#(
   parameter int FRAC_W = 23,
   parameter int EXP_W  = 8,
   parameter int BX_W   = 18,
   localparam int WORD_W  = 1 + EXP_W + FRAC_W,
   localparam int EXP_TOP = (1 << EXP_W) - 1
) (
   input  logic [1:0]             cls,
   input  logic                   sign,
   input  logic [1:0]             rmode,
   input  logic signed [BX_W-1:0] biased,
   input  logic                   subn,
   input  logic [FRAC_W+1:0]      sum,
   input  logic                   inexact,
   input  logic [FRAC_W-1:0]      nan_frac,
   output logic [WORD_W-1:0]      word,
   output spk_flags_t             flags
);
   logic [BX_W-1:0] bump;
   logic            ovf;
   logic            to_inf;

   if (EXP_W + 2 > BX_W) begin : g_bad_exp
      $error("spk_assemble: exponent arithmetic narrower than exponent field");
   end

   assign bump = biased + {{(BX_W-1){1'b0}}, sum[FRAC_W+1]};
   assign ovf  = bump >= BX_W'(EXP_TOP);

   always_comb begin
      unique case (spk_rmode_e'(rmode))
         RM_NEAR_EVEN: to_inf = 1'b1;
         RM_TO_ZERO:   to_inf = 1'b0;
         RM_TO_NEG:    to_inf = sign;
         RM_TO_POS:    to_inf = ~sign;
         default:      to_inf = 1'b1;
      endcase
   end

   always_comb begin
      flags = '0;
      word  = {sign, {(WORD_W-1){1'b0}}};
      unique case (spk_class_e'(cls))
         CLS_ZERO: word = {sign, {(WORD_W-1){1'b0}}};
         CLS_INF:  word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         CLS_NAN:  word = {sign, {EXP_W{1'b1}}, 1'b1, nan_frac[FRAC_W-2:0]};
         CLS_NUM: begin
            if (subn) begin
               flags.unfl = 1'b1;
               flags.inex = inexact;
               word = {sign, {(EXP_W-1){1'b0}}, sum[FRAC_W], sum[FRAC_W-1:0]};
            end else if (ovf) begin
               flags.ovfl  = 1'b1;
               flags.inex  = 1'b1;
               flags.operr = 1'b1;
               if (to_inf)
                  word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
               else
                  word = {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
            end else begin
               flags.inex = inexact;
               word = {sign, bump[EXP_W-1:0], sum[FRAC_W-1:0]};
            end
         end
         default: word = {sign, {(WORD_W-1){1'b0}}};
      endcase
   end

endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
   import spk_pkg::*;
#(
   parameter int MANT_W  = 64,
   parameter int FRAC_W  = 23,
   parameter int EXP_W   = 8,
   parameter int EXPIN_W = 16,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
   localparam int BX_W   = EXPIN_W + 2,
   localparam int KEEP_W = FRAC_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         in_class,
   input  logic               in_sign,
   input  logic [EXPIN_W-1:0] in_exp,
   input  logic [MANT_W-1:0]  in_mant,
   input  logic               in_grd,
   input  logic               in_rnd,
   input  logic               in_stk,
   input  logic [1:0]         rnd_mode,
   input  logic               flag_clr,
   output logic               out_valid,
   output logic [WORD_W-1:0]  out_word,
   output logic               st_inexact,
   output logic               st_underflow,
   output logic               st_overflow,
   output logic               st_operr
);
   if (EXPIN_W < EXP_W + 2) begin : g_bad_expin
      $error("sp_result_packer: input exponent too narrow for the format");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("sp_result_packer: fraction needs at least two bits");
   end

   logic signed [BX_W-1:0] biased;
   logic                   subn;
   logic [KEEP_W-1:0]      kept;
   logic                   guard;
   logic                   rest;
   logic [KEEP_W:0]        sum;
   logic                   inexact;
   logic [WORD_W-1:0]      word_d;
   spk_flags_t             op_flags;
   spk_flags_t             flg_q;

   spk_align #(
      .MANT_W (MANT_W),
      .FRAC_W (FRAC_W),
      .EXPIN_W(EXPIN_W),
      .BIAS   (BIAS)
   ) u_align (
      .exp_in(in_exp),
      .mant  (in_mant),
      .grd   (in_grd),
      .rnd   (in_rnd),
      .stk   (in_stk),
      .biased(biased),
      .subn  (subn),
      .kept  (kept),
      .guard (guard),
      .rest  (rest)
   );

   spk_round #(
      .KEEP_W(KEEP_W)
   ) u_round (
      .kept   (kept),
      .guard  (guard),
      .rest   (rest),
      .sign   (in_sign),
      .rmode  (rnd_mode),
      .sum    (sum),
      .inexact(inexact)
   );

   spk_assemble #(
      .FRAC_W(FRAC_W),
      .EXP_W (EXP_W),
      .BX_W  (BX_W)
   ) u_assemble (
      .cls     (in_class),
      .sign    (in_sign),
      .rmode   (rnd_mode),
      .biased  (biased),
      .subn    (subn),
      .sum     (sum),
      .inexact (inexact),
      .nan_frac(in_mant[MANT_W-2 -: FRAC_W]),
      .word    (word_d),
      .flags   (op_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         flg_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_word <= word_d;
         flg_q <= (flag_clr ? spk_flags_t'('0) : flg_q)
                | (in_valid ? op_flags : spk_flags_t'('0));
      end
   end

   assign st_inexact   = flg_q.inex;
   assign st_underflow = flg_q.unfl;
   assign st_overflow  = flg_q.ovfl;
   assign st_operr     = flg_q.operr;

endmodule

// File: rtl/sp_result_packer_chk.sv
module sp_result_packer_chk #(
   parameter int FRAC_W  = 23,
   parameter int EXP_W   = 8,
   parameter int EXPIN_W = 16,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int BX_W   = EXPIN_W + 2,
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         in_class,
   input logic               in_sign,
   input logic [EXPIN_W-1:0] in_exp,
   input logic [1:0]         rnd_mode,
   input logic               flag_clr,
   input logic               out_valid,
   input logic [WORD_W-1:0]  out_word,
   input logic               st_inexact,
   input logic               st_underflow,
   input logic               st_overflow,
   input logic               st_operr
);
   logic signed [BX_W-1:0] chk_biased;
   assign chk_biased = $signed({{2{in_exp[EXPIN_W-1]}}, in_exp}) + $signed(BX_W'(BIAS));

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'b00) |=>
         (out_word[WORD_W-2:0] == '0 && out_word[WORD_W-1] == $past(in_sign)));

   assert_inf_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'b10) |=>
         (out_word[WORD_W-2:FRAC_W] == '1 && out_word[FRAC_W-1:0] == '0));

   assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'b11) |=>
         (out_word[WORD_W-2:FRAC_W] == '1 && out_word[FRAC_W-1]));

   assert_subnormal_unfl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'b01 && chk_biased <= 0) |=> st_underflow);

   assert_ovfl_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_overflow) |-> (st_inexact && st_operr));

   assert_rz_never_inf_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'b01 && rnd_mode == 2'b01) |=>
         (out_word[WORD_W-2:FRAC_W] != '1));

   assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_clr && st_inexact) |=> st_inexact);
   assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !in_valid) |=>
         (!st_inexact && !st_underflow && !st_overflow && !st_operr));

endmodule

bind sp_result_packer sp_result_packer_chk #(
   .FRAC_W (FRAC_W),
   .EXP_W  (EXP_W),
   .EXPIN_W(EXPIN_W)
) u_chk (.*);

// File: tb/sp_result_packer_test.sv
module sp_result_packer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_class = 2'b00;
   logic        in_sign = 1'b0;
   logic [15:0] in_exp = '0;
   logic [63:0] in_mant = '0;
   logic        in_grd = 1'b0, in_rnd = 1'b0, in_stk = 1'b0;
   logic [1:0]  rnd_mode = 2'b00;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        st_inexact, st_underflow, st_overflow, st_operr;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic        exp_valid = 1'b0;
   logic [31:0] exp_word = '0;
   logic [3:0]  exp_flags = '0;   // {operr, ovfl, unfl, inex}
   string       exp_tag = "R1";
   logic [31:0] lfsr = 32'h1234_5678;

   always #4 clk = ~clk;

   sp_result_packer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_grd(in_grd),
      .in_rnd(in_rnd), .in_stk(in_stk), .rnd_mode(rnd_mode), .flag_clr(flag_clr),
      .out_valid(out_valid), .out_word(out_word), .st_inexact(st_inexact),
      .st_underflow(st_underflow), .st_overflow(st_overflow), .st_operr(st_operr)
   );

   function automatic logic [31:0] rnd32();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr;
   endfunction

   // Behavioural reference: walks the discarded bits one at a time.
   function automatic void ref_pack(input logic [1:0] c, input logic s, input int e,
                                    input logic [63:0] m, input logic g, input logic r,
                                    input logic k, input logic [1:0] md,
                                    output logic [31:0] w, output logic [3:0] f);
      logic [65:0] ext;
      longint kept;
      logic gd, rs, inx, up, inf;
      int b, sh, ex;
      f = 4'b0000;
      w = {s, 31'd0};
      if (c == 2'b10) begin
         w = {s, 8'hff, 23'd0};
      end else if (c == 2'b11) begin
         w = {s, 8'hff, 1'b1, m[61:40]};
      end else if (c == 2'b01) begin
         b = e + 127;
         sh = (b >= 1) ? 40 : 41 - b;
         ext = {m, g, r};
         kept = 0; gd = 1'b0; rs = k;
         for (int i = 0; i < 66; i++) begin
            if (i >= sh + 2) kept = kept + (longint'(ext[i]) << (i - sh - 2));
            else if (i == sh + 1) gd = ext[i];
            else rs = rs | ext[i];
         end
         inx = gd | rs;
         case (md)
            2'b00: up = gd & (rs | kept[0]);
            2'b01: up = 1'b0;
            2'b10: up = s & inx;
            default: up = ~s & inx;
         endcase
         kept = kept + longint'(up);
         if (b < 1) begin
            f = {2'b00, 1'b1, inx};
            w = {s, 31'(kept)};
         end else begin
            ex = b;
            if (kept >= 64'd16777216) begin ex = ex + 1; kept = 0; end
            if (ex >= 255) begin
               f = 4'b1101;
               inf = (md == 2'b00) || (md == 2'b11 && !s) || (md == 2'b10 && s);
               w = inf ? {s, 8'hff, 23'd0} : {s, 8'hfe, 23'h7fffff};
            end else begin
               f = {3'b000, inx};
               w = {s, ex[7:0], kept[22:0]};
            end
         end
      end
   endfunction

   task automatic compare();
      logic [3:0] act_f;
      act_f = {st_operr, st_overflow, st_underflow, st_inexact};
      checks++;
      if (out_valid !== exp_valid) begin
         failures++;
         $display("FAIL %s out_valid actual=%b expected=%b", exp_tag, out_valid, exp_valid);
      end
      if (exp_valid) begin
         checks++;
         if (out_word !== exp_word) begin
            failures++;
            $display("FAIL %s out_word actual=%h expected=%h", exp_tag, out_word, exp_word);
         end
      end
      checks++;
      if (act_f !== exp_flags) begin
         failures++;
         $display("FAIL %s flags actual=%b expected=%b", exp_tag, act_f, exp_flags);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] c, input logic s, input int e,
                       input logic [63:0] m, input logic g, input logic r, input logic k,
                       input logic [1:0] md, input logic clr, input string tag);
      logic [31:0] w;
      logic [3:0]  f;
      @(negedge clk);
      compare();
      in_valid = v; in_class = c; in_sign = s; in_exp = 16'(e); in_mant = m;
      in_grd = g; in_rnd = r; in_stk = k; rnd_mode = md; flag_clr = clr;
      ref_pack(c, s, e, m, g, r, k, md, w, f);
      exp_flags = (clr ? 4'b0000 : exp_flags) | (v ? f : 4'b0000);
      exp_valid = v;
      if (v) exp_word = w;
      exp_tag = tag;
   endtask

   task automatic num(input logic s, input int e, input logic [63:0] m,
                      input logic [2:0] grs, input logic [1:0] md, input string tag);
      step(1'b1, 2'b01, s, e, m, grs[2], grs[1], grs[0], md, 1'b1, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();          // R1 reset state
      rst_n = 1'b1;
      // R2 R3 R4 special classes
      step(1'b1, 2'b00, 1'b1, 0, 64'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R2 zero");
      step(1'b1, 2'b10, 1'b1, 0, 64'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R3 inf");
      step(1'b1, 2'b11, 1'b0, 0, 64'h8123_4567_89ab_cdef, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R4 nan");
      step(1'b1, 2'b11, 1'b1, 0, 64'h8000_0000_0000_0001, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, "R4 nan quiet");
      step(1'b0, 2'b01, 1'b0, 0, 64'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R1 idle");
      // R5 R6 normal rounding
      num(1'b0, 0, 64'h8000_0000_0000_0000, 3'b000, 2'b00, "R5 one exact");
      num(1'b0, 0, 64'h8000_0080_0000_0000, 3'b000, 2'b00, "R5 tie even down");
      num(1'b0, 0, 64'h8000_0180_0000_0000, 3'b000, 2'b00, "R5 tie odd up");
      num(1'b1, 3, 64'h8000_0000_0000_0000, 3'b001, 2'b10, "R6 sticky only neg");
      num(1'b1, 3, 64'h8000_0000_0000_0000, 3'b001, 2'b11, "R5 toward pos neg");
      num(1'b0, 3, 64'h8000_0000_0000_0000, 3'b010, 2'b11, "R5 toward pos");
      num(1'b0, 3, 64'hffff_ffff_ffff_ffff, 3'b111, 2'b01, "R5 toward zero");
      // R7 carry to 2.0
      num(1'b0, 0, 64'hffff_ffff_ffff_ffff, 3'b000, 2'b00, "R7 carry");
      // R8 R9 subnormal
      num(1'b0, -127, 64'h8000_0000_0000_0000, 3'b000, 2'b00, "R8 subnormal exact");
      num(1'b1, -149, 64'h8000_0000_0000_0000, 3'b000, 2'b00, "R8 min subnormal");
      num(1'b0, -150, 64'h8000_0000_0000_0000, 3'b000, 2'b00, "R8 half min tie");
      num(1'b0, -150, 64'h8000_0000_0000_0000, 3'b000, 2'b11, "R8 half min up");
      num(1'b0, -30000, 64'h8000_0000_0000_0000, 3'b000, 2'b11, "R8 far below");
      num(1'b0, -127, 64'hffff_ffff_ffff_ffff, 3'b000, 2'b00, "R9 to min normal");
      // R10 R11 overflow per mode and sign
      for (int md = 0; md < 4; md++) begin
         num(1'b0, 128, 64'h8000_0000_0000_0000, 3'b000, 2'(md), "R11 ovf pos");
         num(1'b1, 128, 64'h8000_0000_0000_0000, 3'b000, 2'(md), "R11 ovf neg");
      end
      num(1'b0, 127, 64'hffff_ffff_ffff_ffff, 3'b000, 2'b00, "R10 round into ovf");
      num(1'b0, 127, 64'hffff_ffff_ffff_ffff, 3'b000, 2'b01, "R10 max finite no ovf");
      num(1'b1, 32767, 64'h8000_0000_0000_0000, 3'b000, 2'b01, "R10 huge exp");
      // R12 sticky flags and clear
      step(1'b1, 2'b01, 1'b0, 0, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, "R12 set inexact");
      step(1'b1, 2'b01, 1'b0, 0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R12 hold");
      step(1'b0, 2'b01, 1'b0, 0, 64'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R12 clear");
      step(1'b1, 2'b01, 1'b0, -130, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R12 unfl");
      step(1'b1, 2'b01, 1'b0, 200, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R12 clear with op");
      // random sweep around both edges
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] a, b2, c2;
         logic [63:0] m;
         logic [1:0]  cls;
         a = rnd32(); b2 = rnd32(); c2 = rnd32();
         m = {1'b1, b2[30:0], c2};
         if (a[3:2] == 2'b00) m[39:0] = '0;
         if (a[5:4] == 2'b00) m[62:40] = '1;
         cls = (a[9:6] == 4'd0) ? a[11:10] : 2'b01;
         step(a[30], cls, a[12], int'(a[24:16] % 9'd330) - 185, m, a[13], a[14], a[15],
              a[27:26], (a[29:28] == 2'b00), "R5 R8 R10 random");
      end
      step(1'b0, 2'b00, 1'b0, 0, 64'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R1 drain");
      @(negedge clk);
      compare();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule